// File: doc/BRIEF.md
# Shared Interrupt Source Router

The router collects a parameterised set of level-sensitive interrupt sources and steers each one to a single interrupt pin of a single processor. Every source holds four items of state: a pending flag, an enable flag, a target pin with a map-to-pin flag, and an optional target processor. A source reaches a processor pin only when it is pending, enabled and routed there. Each processor also has a local compare-timer request. That request has its own mask bit and pin selection and is merged into the same pin outputs.

Software programs the router through a simple word-addressed register port. Writes take effect on the clock edge where `reg_we_i` is high, and reads return combinationally. The address splits into a 4-bit region code `reg_addr_i[11:8]` and an 8-bit index `reg_addr_i[7:0]`. The pin outputs are registered, so the router adds one cycle of latency after any change of state.

Top module: `irq_router`

## Requirements
- R1: `irq_o[c*N_PIN+p]` is the registered OR of the pending bits of every source that is enabled, has a target processor c, and has pin p. A register write that commits on rising edge k shows at the outputs after edge k+1. A change on `src_i` shows after the second rising edge that samples it.
- R2: A source's pending bit takes the new level of `src_i` on every edge where the input differs from its previous sampled value, whether or not the source is enabled. Region 0 returns the pending bits: word w, bit b is source 32*w+b.
- R3: Region 2 is enable-set and region 3 is enable-clear, addressed by word as in R2. A 1 bit sets or clears that source's enable, and a 0 bit leaves it unchanged. Region 1 reads the enables.
- R4: Region 5, index s, is the processor map of source s. A write stores the index of the lowest set data bit. A zero write stores "unmapped", and an unmapped source drives no output. A write whose lowest set bit is N_CPU or higher is ignored. A read returns a one-hot vector of the target, or zero when unmapped.
- R5: Region 4, index s, is the pin map of source s: pin in bits [7:0], map-to-pin flag in bit 31. A write whose pin field exceeds N_PIN-1 is ignored entirely. A read returns the flag in bit 31 and the pin in the low bits.
- R6: A region 6 write is a software trigger. Bit 31 = 1 sets and bit 31 = 0 clears the pending bit of the source indexed by bits [30:0]. An index of N_SRC or more is ignored. If `src_i` of that source changes in the same cycle, the input level wins.
- R7: Region 7, index c, is processor c's local timer setup: map flag in bit 31, mask in bit 30, pin in bits [7:0]. A pin above N_PIN-1 makes the write ignored. When the mask is set, `local_req_i[c]` is ORed into `irq_o[c*N_PIN+pin]` after one rising edge.
- R8: After reset every source is disabled and not pending, with pin 0, the map flag set and no target processor. Each local setup has pin 0, the flag set and the mask set. All outputs are low.
- R9: Words, sources or processors beyond the configured counts read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Synchronous interrupt source levels |
| local_req_i | input | N_CPU | Local compare-timer request per processor |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Region code [11:8], index [7:0] |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | N_CPU*N_PIN | Pin levels, processor-major |

## Verification
The assertions assume that `src_i`, `local_req_i` and the register port are synchronous to `clk_i` and stable around the rising edge. They also assume that a register write lasts exactly the cycle in which `reg_we_i` is high. The bench drives every input on the falling edge and holds the write strobe for a single rising edge, so each write commits exactly once. The bench changes a source input and writes a trigger to that source in the same cycle only in the one test of input-over-trigger priority.

// File: rtl/router_pkg.sv
package router_pkg;
  typedef enum logic [3:0] {
    RG_PEND  = 4'd0,
    RG_EN    = 4'd1,
    RG_ESET  = 4'd2,
    RG_ECLR  = 4'd3,
    RG_PIN   = 4'd4,
    RG_CPU   = 4'd5,
    RG_TRIG  = 4'd6,
    RG_LOCAL = 4'd7
  } region_e;

  // index of lowest set bit, 32 when none
  function automatic logic [5:0] lsb_idx(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd32;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 6'(i);
    return r;
  endfunction
endpackage

// File: rtl/src_slot.sv
module src_slot #(
  parameter int PW = 3,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_i,
  input  logic          trig_we_i,
  input  logic          trig_val_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic          pin_we_i,
  input  logic          pin_ok_i,
  input  logic [PW-1:0] pin_val_i,
  input  logic          flag_val_i,
  input  logic          cpu_we_i,
  input  logic          cpu_vld_val_i,
  input  logic [CW-1:0] cpu_idx_val_i,
  output logic          pend_o,
  output logic          en_o,
  output logic [PW-1:0] pin_o,
  output logic          flag_o,
  output logic          cpu_vld_o,
  output logic [CW-1:0] cpu_idx_o,
  output logic          seen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_o    <= 1'b0;
      pend_o    <= 1'b0;
      en_o      <= 1'b0;
      pin_o     <= '0;
      flag_o    <= 1'b1;
      cpu_vld_o <= 1'b0;
      cpu_idx_o <= '0;
    end else begin
      seen_o <= src_i;
      // input level change has priority over software trigger
      if (src_i != seen_o)  pend_o <= src_i;
      else if (trig_we_i)   pend_o <= trig_val_i;
      if (en_set_i)         en_o <= 1'b1;
      else if (en_clr_i)    en_o <= 1'b0;
      if (pin_we_i && pin_ok_i) begin
        pin_o  <= pin_val_i;
        flag_o <= flag_val_i;
      end
      if (cpu_we_i) begin
        cpu_vld_o <= cpu_vld_val_i;
        cpu_idx_o <= cpu_idx_val_i;
      end
    end
  end

  p_pin_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_we_i && !pin_ok_i) |=> ($stable(pin_o) && $stable(flag_o)));

  p_level_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != seen_o) |=> (pend_o == $past(src_i)));
endmodule

// File: rtl/local_slot.sv
module local_slot #(
  parameter int PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          ok_i,
  input  logic          mask_val_i,
  input  logic          flag_val_i,
  input  logic [PW-1:0] pin_val_i,
  output logic          mask_o,
  output logic          flag_o,
  output logic [PW-1:0] pin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= 1'b1;
      flag_o <= 1'b1;
      pin_o  <= '0;
    end else if (we_i && ok_i) begin
      mask_o <= mask_val_i;
      flag_o <= flag_val_i;
      pin_o  <= pin_val_i;
    end
  end

  p_local_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ok_i) |=> ($stable(pin_o) && $stable(mask_o)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int N_PIN = 6,
  parameter int PW    = 3,
  parameter int CW    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SRC-1:0]           pend_i,
  input  logic [N_SRC-1:0]           en_i,
  input  logic [N_SRC-1:0][PW-1:0]   pin_i,
  input  logic [N_SRC-1:0]           cpu_vld_i,
  input  logic [N_SRC-1:0][CW-1:0]   cpu_idx_i,
  input  logic [N_CPU-1:0]           lreq_i,
  input  logic [N_CPU-1:0]           lmask_i,
  input  logic [N_CPU-1:0][PW-1:0]   lpin_i,
  output logic [N_CPU*N_PIN-1:0]     irq_o
);
  logic [N_CPU*N_PIN-1:0] hit;
  logic                   active;

  always_comb begin
    hit = '0;
    for (int c = 0; c < N_CPU; c++) begin
      for (int p = 0; p < N_PIN; p++) begin
        for (int s = 0; s < N_SRC; s++) begin
          if (pend_i[s] && en_i[s] && cpu_vld_i[s] &&
              cpu_idx_i[s] == CW'(c) && pin_i[s] == PW'(p))
            hit[c*N_PIN+p] = 1'b1;
        end
        if (lreq_i[c] && lmask_i[c] && lpin_i[c] == PW'(p))
          hit[c*N_PIN+p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= hit;
  end

  assign active = |(pend_i & en_i) | |(lreq_i & lmask_i);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active) |-> (irq_o == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import router_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_CPU = 4,
  parameter int N_PIN = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_i,
  input  logic [N_CPU-1:0]       local_req_i,
  input  logic                   reg_we_i,
  input  logic [11:0]            reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  output logic [N_CPU*N_PIN-1:0] irq_o
);
  localparam int PW = (N_PIN > 1) ? $clog2(N_PIN) : 1;
  localparam int CW = (N_CPU > 1) ? $clog2(N_CPU) : 1;
  localparam int NW = (N_SRC + 31) / 32;

  region_e    region;
  logic [7:0] idx;
  logic       pin_ok;
  logic       cpu_ok;
  logic [5:0] low_bit;

  logic [N_SRC-1:0]         pend, en, flag, cpu_vld, seen;
  logic [N_SRC-1:0][PW-1:0] pin;
  logic [N_SRC-1:0][CW-1:0] cpu_idx;
  logic [N_CPU-1:0]         lmask, lflag;
  logic [N_CPU-1:0][PW-1:0] lpin;

  assign region  = region_e'(reg_addr_i[11:8]);
  assign idx     = reg_addr_i[7:0];
  assign pin_ok  = reg_wdata_i[7:0] <= 8'(N_PIN - 1);
  assign low_bit = lsb_idx(reg_wdata_i);
  assign cpu_ok  = (reg_wdata_i == '0) || (low_bit < 6'(N_CPU));

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic in_word;
    assign in_word = (idx == 8'(s / 32));
    src_slot #(.PW(PW), .CW(CW)) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .src_i         (src_i[s]),
      .trig_we_i     (reg_we_i && region == RG_TRIG && reg_wdata_i[30:0] == 31'(s)),
      .trig_val_i    (reg_wdata_i[31]),
      .en_set_i      (reg_we_i && region == RG_ESET && in_word && reg_wdata_i[s % 32]),
      .en_clr_i      (reg_we_i && region == RG_ECLR && in_word && reg_wdata_i[s % 32]),
      .pin_we_i      (reg_we_i && region == RG_PIN && idx == 8'(s)),
      .pin_ok_i      (pin_ok),
      .pin_val_i     (reg_wdata_i[PW-1:0]),
      .flag_val_i    (reg_wdata_i[31]),
      .cpu_we_i      (reg_we_i && region == RG_CPU && idx == 8'(s) && cpu_ok),
      .cpu_vld_val_i (reg_wdata_i != '0),
      .cpu_idx_val_i (low_bit[CW-1:0]),
      .pend_o        (pend[s]),
      .en_o          (en[s]),
      .pin_o         (pin[s]),
      .flag_o        (flag[s]),
      .cpu_vld_o     (cpu_vld[s]),
      .cpu_idx_o     (cpu_idx[s]),
      .seen_o        (seen[s])
    );
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    local_slot #(.PW(PW)) u_local (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (reg_we_i && region == RG_LOCAL && idx == 8'(c)),
      .ok_i       (pin_ok),
      .mask_val_i (reg_wdata_i[30]),
      .flag_val_i (reg_wdata_i[31]),
      .pin_val_i  (reg_wdata_i[PW-1:0]),
      .mask_o     (lmask[c]),
      .flag_o     (lflag[c]),
      .pin_o      (lpin[c])
    );
  end

  irq_combine #(
    .N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN), .PW(PW), .CW(CW)
  ) u_combine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .en_i      (en),
    .pin_i     (pin),
    .cpu_vld_i (cpu_vld),
    .cpu_idx_i (cpu_idx),
    .lreq_i    (local_req_i),
    .lmask_i   (lmask),
    .lpin_i    (lpin),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (region)
      RG_PEND, RG_EN: begin
        for (int s = 0; s < N_SRC; s++)
          if (idx == 8'(s / 32))
            reg_rdata_o[s % 32] = (region == RG_PEND) ? pend[s] : en[s];
      end
      RG_PIN: begin
        for (int s = 0; s < N_SRC; s++)
          if (idx == 8'(s)) begin
            reg_rdata_o[31]     = flag[s];
            reg_rdata_o[PW-1:0] = pin[s];
          end
      end
      RG_CPU: begin
        for (int s = 0; s < N_SRC; s++)
          if (idx == 8'(s) && cpu_vld[s]) reg_rdata_o[cpu_idx[s]] = 1'b1;
      end
      RG_LOCAL: begin
        for (int c = 0; c < N_CPU; c++)
          if (idx == 8'(c)) begin
            reg_rdata_o[31]     = lflag[c];
            reg_rdata_o[30]     = lmask[c];
            reg_rdata_o[PW-1:0] = lpin[c];
          end
      end
      default: reg_rdata_o = '0;
    endcase
  end

  p_cpu_read_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region == RG_CPU) |-> $onehot0(reg_rdata_o));

  p_trig_oob_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && region == RG_TRIG && reg_wdata_i[30:0] >= 31'(N_SRC) &&
     src_i == seen) |=> $stable(pend));

  p_oob_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (region == RG_ESET || region == RG_ECLR) && idx >= 8'(NW))
    |=> $stable(en));
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int N_SRC = 32;
  localparam int N_CPU = 4;
  localparam int N_PIN = 6;
  localparam int NO    = N_CPU * N_PIN;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  src = '0;
  logic [N_CPU-1:0]  lreq = '0;
  logic              we = 1'b0;
  logic [11:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NO-1:0]     irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_router #(.N_SRC(N_SRC), .N_CPU(N_CPU), .N_PIN(N_PIN)) u_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .local_req_i(lreq),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] a(input int rg, input int ix);
    return {4'(rg), 8'(ix)};
  endfunction

  function automatic logic [NO-1:0] pbit(input int c, input int p);
    logic [NO-1:0] v;
    v = '0;
    v[c*N_PIN+p] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int rg, input int ix, input logic [31:0] d);
    addr = a(rg, ix); wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int rg, input int ix, output logic [31:0] d);
    addr = a(rg, ix);
    #1;
    d = rdata;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R8 irq", 32'(irq), 32'h0);
    rd(0, 0, d); chk("R8 pending", d, 32'h0);
    rd(1, 0, d); chk("R8 enable", d, 32'h0);
    rd(4, 0, d); chk("R8 pin map", d, 32'h8000_0000);
    rd(5, 0, d); chk("R8 cpu map", d, 32'h0);
    rd(7, 0, d); chk("R8 local", d, 32'hC000_0000);
  endtask

  task automatic t_route();
    logic [31:0] d;
    src[3] = 1'b1;
    settle(2);
    rd(0, 0, d); chk("R2 pending while disabled", d, 32'h8);
    chk("R2 no irq while disabled", 32'(irq), 32'h0);
    wr(5, 3, 32'h4);
    wr(4, 3, 32'h8000_0002);
    wr(2, 0, 32'h8);
    settle(1);
    chk("R1 routed", 32'(irq), 32'(pbit(2, 2)));
    rd(5, 3, d); chk("R4 one-hot read", d, 32'h4);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(2, 0, 32'h20);
    wr(3, 0, 32'h20);
    rd(1, 0, d); chk("R3 clear only 1 bits", d, 32'h8);
    settle(1);
    chk("R3 other enable kept", 32'(irq), 32'(pbit(2, 2)));
    wr(2, 0, 32'h20);
    rd(1, 0, d); chk("R3 set", d, 32'h28);
  endtask

  task automatic t_or();
    wr(5, 5, 32'h4);
    wr(4, 5, 32'h2);
    src[5] = 1'b1;
    settle(2);
    src[3] = 1'b0;
    settle(2);
    chk("R1 OR keeps pin", 32'(irq), 32'(pbit(2, 2)));
    src[5] = 1'b0;
    settle(2);
    chk("R1 all drop", 32'(irq), 32'h0);
  endtask

  task automatic t_cpu_map();
    logic [31:0] d;
    wr(6, 0, 32'h8000_0003);
    settle(1);
    chk("R6 trigger set", 32'(irq), 32'(pbit(2, 2)));
    wr(5, 3, 32'hA);
    settle(1);
    chk("R4 lowest bit", 32'(irq), 32'(pbit(1, 2)));
    rd(5, 3, d); chk("R4 read lowest", d, 32'h2);
    wr(5, 3, 32'h10);
    settle(1);
    chk("R4 too-high ignored", 32'(irq), 32'(pbit(1, 2)));
    rd(5, 3, d); chk("R4 too-high read", d, 32'h2);
    wr(5, 3, 32'h0);
    settle(1);
    chk("R4 unmapped quiet", 32'(irq), 32'h0);
    rd(5, 3, d); chk("R4 unmapped read", d, 32'h0);
  endtask

  task automatic t_pin_map();
    logic [31:0] d;
    wr(5, 3, 32'h1);
    wr(4, 3, 32'h8000_0006);
    rd(4, 3, d); chk("R5 illegal pin ignored", d, 32'h8000_0002);
    settle(1);
    chk("R5 irq on old pin", 32'(irq), 32'(pbit(0, 2)));
    wr(4, 3, 32'h5);
    rd(4, 3, d); chk("R5 store pin and flag", d, 32'h5);
    settle(1);
    chk("R5 irq moved", 32'(irq), 32'(pbit(0, 5)));
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    wr(6, 0, 32'h0000_0003);
    settle(1);
    chk("R6 trigger clear", 32'(irq), 32'h0);
    rd(0, 0, d); chk("R6 pending cleared", d, 32'h0);
    wr(6, 0, 32'h8000_0028);
    rd(0, 0, d); chk("R6 oob index ignored", d, 32'h0);
    rd(0, 1, d); chk("R9 pending word oob", d, 32'h0);
    src[7] = 1'b1;
    wr(6, 0, 32'h0000_0007);
    rd(0, 0, d); chk("R6 input wins", d, 32'h80);
    src[7] = 1'b0;
    settle(2);
    rd(0, 0, d); chk("R2 follows fall", d, 32'h0);
  endtask

  task automatic t_local();
    logic [31:0] d;
    lreq[1] = 1'b1;
    settle(1);
    chk("R7 local on pin0", 32'(irq), 32'(pbit(1, 0)));
    wr(7, 1, 32'h8000_0004);
    settle(1);
    chk("R7 masked", 32'(irq), 32'h0);
    wr(7, 1, 32'hC000_0003);
    settle(1);
    chk("R7 remapped", 32'(irq), 32'(pbit(1, 3)));
    wr(7, 1, 32'hC000_0009);
    rd(7, 1, d); chk("R7 illegal pin ignored", d, 32'hC000_0003);
    lreq[1] = 1'b0;
    settle(1);
    chk("R7 release", 32'(irq), 32'h0);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    wr(2, 1, 32'hFFFF_FFFF);
    rd(1, 1, d); chk("R9 enable word oob", d, 32'h0);
    rd(1, 0, d); chk("R9 enables intact", d, 32'h28);
    wr(4, 40, 32'h3);
    rd(4, 40, d); chk("R9 pin map oob", d, 32'h0);
    rd(7, 5, d); chk("R9 local oob", d, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    settle(2);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_route();
    t_enable();
    t_or();
    t_cpu_map();
    t_pin_map();
    t_trigger();
    t_local();
    t_oob();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule